// File: doc/BRIEF.md
# Revolution Carry Pulse Generator

This block sits beside a position up/down counter and drives a single pulse line for an external revolution counter. Each counter step is announced by a strobe, `busy_i`, and the counter flags a step that wraps through its major carry (all ones to all zeros, or all zeros to all ones) on `carry_i`. The block counts the wrap as a new revolution only when the carry flag coincides with a rising strobe edge, whichever way the count is moving. It then raises `rev_pulse_o` and holds it for a minimum number of clock cycles.

After that minimum, the pulse normally drops before the next step strobe arrives. If the direction flag changes while the pulse is high, the pulse is held. It is released only after the direction has stayed unchanged across a set number of consecutive strobe rising edges, two by default. This keeps a dithering axis from releasing the pulse while it is still undecided. The output-latch inhibit signal is routed to the block but has no influence on the pulse.

Top module: `rev_carry_pulse`

## Requirements
- R1: While `rst_ni` is low, `rev_pulse_o` is 0, and any direction hold is discarded, independent of the clock.
- R2: A wrap is qualified when, at a clock edge, `busy_i` is 1, `busy_i` was 0 at the previous edge, and `carry_i` is 1. `rev_pulse_o` is 1 from that edge on, and `dir_i` may be either 0 or 1.
- R3: `carry_i` has no effect without a `busy_i` rising edge. A carry flag asserted while `busy_i` is low, or raised while `busy_i` is already high, leaves `rev_pulse_o` at 0.
- R4: If `dir_i` does not change while the pulse is high, `rev_pulse_o` stays high for exactly `MIN_W` clock cycles.
- R5: When strobe rising edges are more than `MIN_W` cycles apart, the pulse returns low before the next strobe rising edge.
- R6: At any edge where `rev_pulse_o` is 1 and `dir_i` differs from its value at the previous edge, the pulse stays 1 through the following cycle, and the block enters the held state.
- R7: In the held state, the pulse falls only after both of these are true: `MIN_W` has elapsed, and `STABLE_EDGES` strobe rising edges have occurred with no `dir_i` change since the last one. A `dir_i` change restarts this tally. It falls at the edge that follows the completing strobe edge.
- R8: `inhibit_i` has no effect on `rev_pulse_o`.
- R9: A qualified wrap while the pulse is already high restarts the `MIN_W` window and clears the held state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| busy_i | input | 1 | Step strobe from the position counter |
| dir_i | input | 1 | Count direction flag |
| carry_i | input | 1 | Major-carry wrap indication from the counter |
| inhibit_i | input | 1 | Output-latch inhibit, ignored by this block |
| rev_pulse_o | output | 1 | Revolution pulse |

## Verification
The bench builds the block with `MIN_W = 6` and `STABLE_EDGES = 2`. A short width lets strobe spacing fall on either side of the window: gaps longer than six cycles show the normal early release, and gaps shorter than six show a retriggered pulse. Two required edges are enough to show a held pulse surviving one steady strobe edge and then being reset by a direction flip that happens between strobes.

// File: rtl/rcp_pkg.sv
package rcp_pkg;
  typedef struct packed {
    logic rise;     // busy rising edge
    logic wrap;     // qualified carry
    logic dir_chg;  // direction differs from last edge
  } step_evt_t;
endpackage

// File: rtl/rcp_step_detect.sv
module rcp_step_detect
  import rcp_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      busy_i,
  input  logic      dir_i,
  input  logic      carry_i,
  output step_evt_t evt_o
);
  logic busy_q, dir_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      dir_q  <= 1'b0;
    end else begin
      busy_q <= busy_i;
      dir_q  <= dir_i;
    end
  end

  always_comb begin
    evt_o.rise    = busy_i & ~busy_q;
    evt_o.wrap    = busy_i & ~busy_q & carry_i;
    evt_o.dir_chg = dir_i ^ dir_q;
  end
endmodule

// File: rtl/rcp_width_timer.sv
module rcp_width_timer #(
  parameter int unsigned MIN_W = 60
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic tick_i,
  output logic done_o
);
  generate
    if (MIN_W <= 1) begin : g_single
      logic unused_ctl;
      assign unused_ctl = load_i ^ tick_i ^ clk_i ^ rst_ni;
      assign done_o = 1'b1;
    end else begin : g_count
      localparam int unsigned CW = $clog2(MIN_W);
      localparam logic [CW-1:0] LOAD = CW'(MIN_W - 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                    cnt_q <= '0;
        else if (load_i)                cnt_q <= LOAD;
        else if (tick_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
      end

      assign done_o = (cnt_q == '0);
    end
  endgenerate
endmodule

// File: rtl/rcp_dir_track.sv
module rcp_dir_track #(
  parameter int unsigned STABLE_EDGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic active_i,
  input  logic chg_i,
  input  logic rise_i,
  output logic hold_o,
  output logic settled_o
);
  localparam int unsigned SW = $clog2(STABLE_EDGES + 1);
  localparam logic [SW-1:0] TGT = SW'(STABLE_EDGES);

  logic          hold_q;
  logic [SW-1:0] stab_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= 1'b0;
      stab_q <= '0;
    end else if (clr_i) begin
      hold_q <= 1'b0;
      stab_q <= '0;
    end else if (active_i) begin
      if (chg_i) begin
        hold_q <= 1'b1;
        stab_q <= '0;
      end else if (rise_i && stab_q != TGT) begin
        stab_q <= stab_q + 1'b1;
      end
    end
  end

  assign hold_o    = hold_q;
  assign settled_o = (stab_q == TGT);
endmodule

// File: rtl/rev_carry_pulse.sv
module rev_carry_pulse
  import rcp_pkg::*;
#(
  parameter int unsigned MIN_W        = 60,
  parameter int unsigned STABLE_EDGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic busy_i,
  input  logic dir_i,
  input  logic carry_i,
  input  logic inhibit_i,
  output logic rev_pulse_o
);
  step_evt_t evt;
  logic pulse_q, width_done, hold, settled, release_now;
  logic unused_inhibit;

  // inhibit only gates output latches elsewhere
  assign unused_inhibit = inhibit_i;

  rcp_step_detect u_step (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .busy_i (busy_i),
    .dir_i  (dir_i),
    .carry_i(carry_i),
    .evt_o  (evt)
  );

  rcp_width_timer #(.MIN_W(MIN_W)) u_width (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(evt.wrap),
    .tick_i(pulse_q),
    .done_o(width_done)
  );

  // never release in a cycle that itself changes direction
  assign release_now = pulse_q & width_done & ~evt.dir_chg & (~hold | settled);

  rcp_dir_track #(.STABLE_EDGES(STABLE_EDGES)) u_dir (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (evt.wrap | release_now),
    .active_i (pulse_q),
    .chg_i    (evt.dir_chg),
    .rise_i   (evt.rise),
    .hold_o   (hold),
    .settled_o(settled)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          pulse_q <= 1'b0;
    else if (evt.wrap)    pulse_q <= 1'b1;
    else if (release_now) pulse_q <= 1'b0;
  end

  assign rev_pulse_o = pulse_q;
endmodule

// File: rtl/rev_carry_pulse_chk.sv
module rev_carry_pulse_chk #(
  parameter int unsigned MIN_W = 60
) (
  input logic clk_i,
  input logic rst_ni,
  input logic busy_i,
  input logic dir_i,
  input logic carry_i,
  input logic rev_pulse_o
);
  logic [31:0] hi_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          hi_cnt <= '0;
    else if (rev_pulse_o) hi_cnt <= (hi_cnt == 32'hFFFF_FFFF) ? hi_cnt : hi_cnt + 1;
    else                  hi_cnt <= '0;
  end

  // R1
  always @(posedge clk_i) if (!rst_ni) reset_low_chk: assert (!rev_pulse_o);

  // R2
  wrap_fires_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !$past(busy_i) && carry_i) |=> rev_pulse_o);

  // R3
  rise_qualified_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rev_pulse_o) |-> ($past(busy_i) && !$past(busy_i, 2) && $past(carry_i)));

  // R4
  min_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rev_pulse_o) |-> (hi_cnt >= MIN_W));

  // R6
  dir_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rev_pulse_o && (dir_i != $past(dir_i))) |=> rev_pulse_o);
endmodule

bind rev_carry_pulse rev_carry_pulse_chk #(.MIN_W(MIN_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .busy_i     (busy_i),
  .dir_i      (dir_i),
  .carry_i    (carry_i),
  .rev_pulse_o(rev_pulse_o)
);

// File: tb/rev_carry_pulse_bench.sv
module rev_carry_pulse_bench;
  localparam int MIN_W  = 6;
  localparam int STABLE = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic busy = 1'b0, dir = 1'b0, carry = 1'b0, inhibit = 1'b0;
  logic pulse;

  int errs = 0, checks = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  rev_carry_pulse #(.MIN_W(MIN_W), .STABLE_EDGES(STABLE)) u_rev_carry_pulse (
    .clk_i(clk), .rst_ni(rst_n), .busy_i(busy), .dir_i(dir),
    .carry_i(carry), .inhibit_i(inhibit), .rev_pulse_o(pulse)
  );

  // behavioural reference
  logic m_pulse, m_hold, m_pb, m_pd;
  int   m_left, m_stab;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pulse = 0; m_hold = 0; m_pb = 0; m_pd = 0; m_left = 0; m_stab = 0;
    end else begin
      automatic bit rise = busy && !m_pb;
      automatic bit chg  = (dir != m_pd);
      if (rise && carry) begin
        m_pulse = 1; m_left = MIN_W - 1; m_hold = 0; m_stab = 0;
      end else if (m_pulse) begin
        if (m_left == 0 && !chg && (!m_hold || m_stab >= STABLE)) begin
          m_pulse = 0; m_hold = 0; m_stab = 0;
        end else begin
          if (m_left > 0) m_left--;
          if (chg) begin m_hold = 1; m_stab = 0; end
          else if (rise && m_stab < STABLE) m_stab++;
        end
      end
      m_pb = busy; m_pd = dir;
    end
  end

  task automatic chk(string req, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  // width of the last completed high run
  int hi_run = 0, last_w = 0;
  always @(negedge clk) begin
    if (!rst_n) begin hi_run = 0; end
    else if (pulse) hi_run++;
    else begin if (hi_run > 0) last_w = hi_run; hi_run = 0; end
    if (rst_n) chk(cur_req, pulse, m_pulse, "per-cycle model");
  end

  task automatic cyc(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic step(logic c, logic d, int gap);
    busy = 1; carry = c; dir = d;
    cyc(2);
    busy = 0; carry = 0;
    cyc(gap);
  endtask

  task automatic chk_int(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  initial begin
    #(200000 * 5);
    errs++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    cyc(3);
    @(negedge clk); chk("R1", pulse, 1'b0, "reset state");
    @(posedge clk); #1; rst_n = 1; cyc(2);

    // R3: steps without carry, carry without rising busy
    cur_req = "R3";
    step(0, 1, 4);
    carry = 1; cyc(3); carry = 0;
    busy = 1; cyc(1); carry = 1; cyc(2); busy = 0; carry = 0; cyc(3);
    @(negedge clk); chk("R3", pulse, 1'b0, "no pulse without qualified wrap");
    chk_int("R3", last_w, 0, "no high run seen");
    cyc(1);

    // R2/R4/R5: up wrap, normal width, early release
    cur_req = "R4";
    step(1, 1, 10);
    chk_int("R4", last_w, MIN_W, "width up wrap");
    chk("R5", pulse, 1'b0, "released before next strobe");
    step(0, 1, 10);

    // R2: down wrap
    cur_req = "R2";
    last_w = 0;
    step(1, 0, 10);
    chk_int("R2", last_w, MIN_W, "width down wrap");

    // R6/R7: direction flip while high, release after two steady strobes
    cur_req = "R7";
    step(1, 0, 1);
    step(0, 1, 10);
    @(negedge clk); chk("R6", pulse, 1'b1, "held past width after flip");
    cyc(1);
    step(0, 1, 10);
    @(negedge clk); chk("R7", pulse, 1'b1, "held after one steady strobe");
    cyc(1);
    step(0, 1, 10);
    @(negedge clk); chk("R7", pulse, 1'b0, "released after two steady strobes");
    checks++; if (last_w <= MIN_W) begin errs++; $display("FAIL R7 held width: actual=%0d expected>%0d", last_w, MIN_W); end
    cyc(1);

    // R7: flip between strobes restarts the tally
    step(1, 1, 1);
    step(0, 0, 4);
    step(0, 0, 3);
    dir = 1; cyc(4);
    step(0, 1, 10);
    @(negedge clk); chk("R7", pulse, 1'b1, "tally restarted by flip");
    cyc(1);
    step(0, 1, 10);
    @(negedge clk); chk("R7", pulse, 1'b0, "release after restarted tally");
    cyc(1);

    // R8: inhibit toggling has no effect
    cur_req = "R8";
    last_w = 0;
    inhibit = 1;
    busy = 1; carry = 1; cyc(1); inhibit = 0; cyc(1); busy = 0; carry = 0;
    inhibit = 1; cyc(3); inhibit = 0; cyc(6);
    chk_int("R8", last_w, MIN_W, "width under inhibit");
    inhibit = 1; carry = 1; cyc(3); carry = 0; inhibit = 0;
    @(negedge clk); chk("R8", pulse, 1'b0, "inhibit does not fire");
    cyc(1);

    // R9: retrigger
    cur_req = "R9";
    step(1, 1, 1);
    step(1, 1, 12);
    chk_int("R9", last_w, MIN_W + 3, "retriggered width");

    // R1: async reset mid-pulse
    cur_req = "R1";
    step(1, 1, 0);
    rst_n = 0; #0.5;
    chk("R1", pulse, 1'b0, "async clear mid-pulse");
    cyc(2);
    @(negedge clk); chk("R1", pulse, 1'b0, "low during reset");
    @(posedge clk); #1; rst_n = 1; cyc(3);
    @(negedge clk); chk("R1", pulse, 1'b0, "no pulse after reset");

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule